// File: doc/BRIEF.md
# Cycle and Stall Performance Counters

This block holds two profiling counters for an embedded processor core. The first counter, the cycle counter, advances on every clock in which the core is enabled and the profiling enable is set. The second counter, the stall counter, advances only on those same counted clocks in which the core could not fetch a new instruction. Because the stall counter only moves when the cycle counter moves, it can never run ahead of it.

The cycle counter does not wrap. When it reaches its all-ones value it holds there and asks the surrounding control register to drop the profiling enable. A host can read either count through a one-cycle read port. A host can also issue a clear strobe, which zeroes both counters together. The clear is accepted only while counting is switched off.

Only the counters live here. The stall condition and the control register that holds the two enables come from outside the block. The read and clear interface is plain control rather than a stream. A read is always accepted and answers exactly one cycle later, so there is no back-pressure.

Top module: `perfcnt_top`

## Requirements
- R1: On every clock edge where `core_en` and `cnt_en` are both 1 and `cycle_cnt` is below all-ones, `cycle_cnt` increases by exactly one.
- R2: While either `core_en` or `cnt_en` is 0, both counts hold their values, whatever `fetch_stall` does. Once both enables are 1 again, counting resumes from the held value.
- R3: The cycle count stops at all-ones (2^CNT_W-1) and does not wrap. `cnt_en_clr_req` is 1 exactly while `cycle_cnt` is all-ones and `cnt_en` is 1.
- R4: A `host_clr` strobe with `core_en` or `cnt_en` at 0 sets both counts to zero on that clock edge.
- R5: A `host_clr` strobe with both enables at 1 is ignored: neither count is cleared, and counting proceeds as in R1 and R6.
- R6: `stall_cnt` increases by one on each edge where the cycle count advances (R1) and `fetch_stall` is 1. It otherwise holds, so `stall_cnt` never exceeds `cycle_cnt`.
- R7: On the edge that takes `cycle_cnt` to all-ones, a stall in that cycle is still counted. After that edge, neither count advances.
- R8: A read with `host_rd_en` = 1 returns, on the next cycle, `host_rd_valid` = 1 and `host_rd_data` equal to the selected count as it stood before that edge. The selector `host_rd_sel` picks the count: 0 = cycle count, 1 = stall count. With no read, `host_rd_valid` is 0.
- R9: After reset, both counts, `cnt_en_clr_req` and `host_rd_valid` are 0.

Here is how the outputs line up in time:
- Both count outputs are registered. An increment or clear shows up on the edge that samples its cause.
- The clear request is combinational from the registered cycle count. It is therefore high from the edge on which the count saturates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_en | input | 1 | Core is enabled to fetch instructions |
| cnt_en | input | 1 | Profiling counters are enabled |
| fetch_stall | input | 1 | Core failed to fetch a new instruction this cycle |
| host_clr | input | 1 | Clear strobe for both counts |
| host_rd_en | input | 1 | Read request |
| host_rd_sel | input | 1 | Read select: 0 cycle count, 1 stall count |
| host_rd_data | output | CNT_W | Read data, valid one cycle after request |
| host_rd_valid | output | 1 | Read data is valid |
| cycle_cnt | output | CNT_W | Current cycle count |
| stall_cnt | output | CNT_W | Current stall count |
| cnt_en_clr_req | output | 1 | Request to drop the counter enable at saturation |

## Verification
A count change (R1, R2, R4 to R7) is due one clock after the inputs that cause it. The clear request (R3) is due in the same cycle that `cycle_cnt` reaches all-ones. Read data (R8) is due one clock after `host_rd_en` and carries the value from before that edge.

The bench changes inputs just after a falling edge and samples outputs at the next falling edge. Each check therefore sees the result of exactly one rising edge. The bench uses a narrow counter width, so saturation and the stall counted on the saturating edge can be reached directly.

// File: rtl/perfcnt_pkg.sv
package perfcnt_pkg;
  // Read select encoding of host_rd_sel
  typedef enum logic {
    SEL_CYCLE = 1'b0,
    SEL_STALL = 1'b1
  } perf_sel_e;
endpackage

// File: rtl/perfcnt_qual.sv
// Qualifies counting and clear requests from the enables.
module perfcnt_qual (
  input  logic core_en,
  input  logic cnt_en,
  input  logic fetch_stall,
  input  logic host_clr,
  input  logic cyc_at_max,
  output logic cyc_inc,
  output logic stl_inc,
  output logic clr_ok,
  output logic sat_req
);
  logic counting;

  always_comb begin
    counting = core_en & cnt_en;
    cyc_inc  = counting & ~cyc_at_max;
    stl_inc  = cyc_inc & fetch_stall;
    clr_ok   = host_clr & ~counting;
    sat_req  = cyc_at_max & cnt_en;
  end
endmodule

// File: rtl/perfcnt_ctr.sv
// Saturating up-counter with synchronous clear.
module perfcnt_ctr #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             at_max
);
  localparam logic [CNT_W-1:0] MAX_VAL = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (inc && (cnt != MAX_VAL)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign at_max = (cnt == MAX_VAL);
endmodule

// File: rtl/perfcnt_rdport.sv
// One-cycle registered read port.
module perfcnt_rdport
  import perfcnt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             rd_sel,
  input  logic [CNT_W-1:0] cyc_val,
  input  logic [CNT_W-1:0] stl_val,
  output logic [CNT_W-1:0] rd_data,
  output logic             rd_valid
);
  perf_sel_e        sel;
  logic [CNT_W-1:0] mux_val;

  always_comb begin
    sel     = perf_sel_e'(rd_sel);
    mux_val = (sel == SEL_STALL) ? stl_val : cyc_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_data <= mux_val;
      end
    end
  end
endmodule

// File: rtl/perfcnt_top.sv
module perfcnt_top #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_en,
  input  logic             cnt_en,
  input  logic             fetch_stall,
  input  logic             host_clr,
  input  logic             host_rd_en,
  input  logic             host_rd_sel,
  output logic [CNT_W-1:0] host_rd_data,
  output logic             host_rd_valid,
  output logic [CNT_W-1:0] cycle_cnt,
  output logic [CNT_W-1:0] stall_cnt,
  output logic             cnt_en_clr_req
);
  logic cyc_inc, stl_inc, clr_ok, cyc_at_max, stl_at_max;

  perfcnt_qual u_qual (
    .core_en     (core_en),
    .cnt_en      (cnt_en),
    .fetch_stall (fetch_stall),
    .host_clr    (host_clr),
    .cyc_at_max  (cyc_at_max),
    .cyc_inc     (cyc_inc),
    .stl_inc     (stl_inc),
    .clr_ok      (clr_ok),
    .sat_req     (cnt_en_clr_req)
  );

  perfcnt_ctr #(.CNT_W(CNT_W)) u_cyc (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (cyc_inc),
    .clr    (clr_ok),
    .cnt    (cycle_cnt),
    .at_max (cyc_at_max)
  );

  // Stall count shares the clear and never outruns the cycle count
  perfcnt_ctr #(.CNT_W(CNT_W)) u_stl (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (stl_inc),
    .clr    (clr_ok),
    .cnt    (stall_cnt),
    .at_max (stl_at_max)
  );

  perfcnt_rdport #(.CNT_W(CNT_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (host_rd_en),
    .rd_sel   (host_rd_sel),
    .cyc_val  (cycle_cnt),
    .stl_val  (stall_cnt),
    .rd_data  (host_rd_data),
    .rd_valid (host_rd_valid)
  );

  logic unused_ok;
  assign unused_ok = stl_at_max;
endmodule

// File: rtl/perfcnt_chk.sv
module perfcnt_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             core_en,
  input logic             cnt_en,
  input logic             fetch_stall,
  input logic             host_clr,
  input logic             host_rd_en,
  input logic             host_rd_sel,
  input logic [CNT_W-1:0] host_rd_data,
  input logic             host_rd_valid,
  input logic [CNT_W-1:0] cycle_cnt,
  input logic [CNT_W-1:0] stall_cnt,
  input logic             cnt_en_clr_req
);
  localparam logic [CNT_W-1:0] MAX_VAL = {CNT_W{1'b1}};

  // R1
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en && cnt_en && cycle_cnt != MAX_VAL) |=> (cycle_cnt == $past(cycle_cnt) + 1'b1));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(core_en && cnt_en) && !host_clr) |=> ($stable(cycle_cnt) && $stable(stall_cnt)));

  // R3
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_cnt == MAX_VAL && !host_clr) |=> (cycle_cnt == MAX_VAL));

  // R3
  sat_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_cnt == MAX_VAL && cnt_en) |-> cnt_en_clr_req);

  // R4
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_clr && !(core_en && cnt_en)) |=> (cycle_cnt == '0 && stall_cnt == '0));

  // R6
  stall_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_cnt <= cycle_cnt);

  // R7
  frozen_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_cnt == MAX_VAL && !host_clr) |=> $stable(stall_cnt));

  // R8
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_en |=> (host_rd_valid &&
      host_rd_data == ($past(host_rd_sel) ? $past(stall_cnt) : $past(cycle_cnt))));

  logic unused_in;
  assign unused_in = fetch_stall;
endmodule

bind perfcnt_top perfcnt_chk #(.CNT_W(CNT_W)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .core_en        (core_en),
  .cnt_en         (cnt_en),
  .fetch_stall    (fetch_stall),
  .host_clr       (host_clr),
  .host_rd_en     (host_rd_en),
  .host_rd_sel    (host_rd_sel),
  .host_rd_data   (host_rd_data),
  .host_rd_valid  (host_rd_valid),
  .cycle_cnt      (cycle_cnt),
  .stall_cnt      (stall_cnt),
  .cnt_en_clr_req (cnt_en_clr_req)
);

// File: tb/perfcnt_top_tb_top.sv
`timescale 1ns/1ps
module perfcnt_top_tb_top;
  localparam int unsigned W = 10;
  localparam int unsigned MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic core_en = 1'b0, cnt_en = 1'b0, fetch_stall = 1'b0;
  logic host_clr = 1'b0, host_rd_en = 1'b0, host_rd_sel = 1'b0;
  logic [W-1:0] host_rd_data, cycle_cnt, stall_cnt;
  logic host_rd_valid, cnt_en_clr_req;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  perfcnt_top #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .core_en(core_en), .cnt_en(cnt_en),
    .fetch_stall(fetch_stall), .host_clr(host_clr), .host_rd_en(host_rd_en),
    .host_rd_sel(host_rd_sel), .host_rd_data(host_rd_data),
    .host_rd_valid(host_rd_valid), .cycle_cnt(cycle_cnt),
    .stall_cnt(stall_cnt), .cnt_en_clr_req(cnt_en_clr_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Apply inputs after a falling edge, hold across one rising edge
  task automatic step(input logic ce, input logic en, input logic st,
                      input logic clr, input logic rd, input logic sel);
    core_en = ce; cnt_en = en; fetch_stall = st;
    host_clr = clr; host_rd_en = rd; host_rd_sel = sel;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R9 cycle", int'(cycle_cnt), 0);
    chk("R9 stall", int'(stall_cnt), 0);
    chk("R9 clr_req", int'(cnt_en_clr_req), 0);
    chk("R9 rd_valid", int'(host_rd_valid), 0);
  endtask

  task automatic t_count;
    for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 0, 0);
    chk("R1 cycle after 5", int'(cycle_cnt), 5);
    chk("R1 stall unchanged", int'(stall_cnt), 0);
    for (int i = 0; i < 3; i++) step(1, 1, 1, 0, 0, 0);
    chk("R6 cycle", int'(cycle_cnt), 8);
    chk("R6 stall", int'(stall_cnt), 3);
  endtask

  task automatic t_pause;
    step(0, 1, 1, 0, 0, 0);
    step(0, 1, 1, 0, 0, 0);
    chk("R2 core off cycle", int'(cycle_cnt), 8);
    chk("R2 core off stall", int'(stall_cnt), 3);
    step(1, 0, 1, 0, 0, 0);
    step(1, 0, 1, 0, 0, 0);
    chk("R2 cnt off cycle", int'(cycle_cnt), 8);
    chk("R2 cnt off stall", int'(stall_cnt), 3);
    step(1, 1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0);
    chk("R2 resume", int'(cycle_cnt), 10);
  endtask

  task automatic t_read;
    step(1, 1, 0, 0, 1, 0);
    chk("R8 valid", int'(host_rd_valid), 1);
    chk("R8 cycle read pre-edge", int'(host_rd_data), 10);
    chk("R1 counted during read", int'(cycle_cnt), 11);
    step(0, 0, 0, 0, 1, 1);
    chk("R8 stall read", int'(host_rd_data), 3);
    step(0, 0, 0, 0, 0, 0);
    chk("R8 valid drops", int'(host_rd_valid), 0);
  endtask

  task automatic t_clear;
    step(1, 1, 0, 1, 0, 0);
    chk("R5 cycle not cleared", int'(cycle_cnt), 12);
    chk("R5 stall not cleared", int'(stall_cnt), 3);
    step(1, 0, 0, 1, 0, 0);
    chk("R4 cycle cleared", int'(cycle_cnt), 0);
    chk("R4 stall cleared", int'(stall_cnt), 0);
    for (int i = 0; i < 2; i++) step(1, 1, 1, 0, 0, 0);
    step(0, 1, 0, 1, 0, 0);
    chk("R4 core-off clear cycle", int'(cycle_cnt), 0);
    chk("R4 core-off clear stall", int'(stall_cnt), 0);
  endtask

  task automatic t_saturate;
    for (int i = 0; i < int'(MAXV) - 1; i++) step(1, 1, 0, 0, 0, 0);
    chk("R3 below max", int'(cycle_cnt), MAXV - 1);
    chk("R3 no req below max", int'(cnt_en_clr_req), 0);
    step(1, 1, 1, 0, 0, 0);
    chk("R7 reaches max", int'(cycle_cnt), MAXV);
    chk("R7 stall on saturating edge", int'(stall_cnt), 1);
    chk("R3 req at max", int'(cnt_en_clr_req), 1);
    for (int i = 0; i < 3; i++) step(1, 1, 1, 0, 0, 0);
    chk("R3 no wrap", int'(cycle_cnt), MAXV);
    chk("R7 stall frozen", int'(stall_cnt), 1);
    step(1, 0, 1, 0, 0, 0);
    chk("R3 req drops with cnt_en", int'(cnt_en_clr_req), 0);
    step(1, 0, 0, 1, 0, 0);
    chk("R4 clear after saturation", int'(cycle_cnt), 0);
  endtask

  bit done = 0;

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_pause();
    t_read();
    t_clear();
    t_saturate();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule